// File: doc/BRIEF.md
# Static Memory Bank Timing Controller

This block sequences single accesses to asynchronous SRAM-, ROM- or peripheral-style devices on an external parallel bus with up to four chip-select banks. An internal client places one request on a valid/ready port: target bank, byte offset within the bank, write flag, write data and byte enables. The block then walks a fixed phase sequence. It drives the address, drops the bank's chip-select, asserts the output-enable or write-enable strobe, and holds the strobe for the access time. It then releases the strobe, the chip-select and finally the address, and returns to idle. For reads it samples the data bus on the last strobe cycle and reports the value on a one-cycle response strobe.

Every bank carries its own settings, supplied as plain input vectors: six cycle counts, a data width of one or two bytes, and a page-read enable. When page reads are enabled, a read keeps the strobe low for four consecutive beats at stepping addresses. Each beat after the first uses the shorter page time. The settings are captured when a request is accepted, so they may change freely while the block is idle.

Top module: `smem_timing_ctrl`

## Requirements
- R1: A request is accepted on a rising edge with `req_valid` and `req_ready` both high. Only `mem_cs_n[req_bank]` goes low during the access, and the other chip-selects stay high. The timing, width and page settings used are those of `req_bank`.
- R2: During reset and after it, `req_ready` is 1, all chip-selects, `mem_oe_n` and `mem_we_n` are 1, `mem_be_n` is 2'b11, and `rsp_valid` and `mem_dout_en` are 0. A reset in the middle of an access returns all of these to that state.
- R3: Each bank's timing vector is 25 bits: {address setup[24:21], chip-select setup[20:17], access[16:12], chip-select hold[11:8], address hold[7:4], page access[3:0]}. With the cycle after acceptance counted as t=0, the chip-select goes low at t = address setup.
- R4: The strobe goes low a further chip-select-setup cycles after the chip-select falls. A setup value of 0 asserts the strobe together with the chip-select.
- R5: The strobe stays low for access+1 cycles. On a read, data is sampled on the last strobe cycle and appears on `rsp_rdata` with `rsp_valid` high for one cycle, in the cycle after that.
- R6: The chip-select rises chip-select-hold cycles after the strobe rises. The access ends address-hold cycles after that, and `req_ready` is high again at t = the sum of all phase lengths.
- R7: With page mode set for the bank, a read holds the strobe for four beats. The first beat lasts access+1 cycles and each later beat lasts page-access+1 cycles. The address advances by the bank's width in bytes at each beat start, and each beat yields its own response.
- R8: `cfg_wide` bit = 0 selects an 8-bit bank: only the low byte lane is enabled, `rsp_rdata[15:8]` is 0 and page addresses step by 1. A value of 1 selects 16 bits: both lanes are used and page addresses step by 2.
- R9: A write uses `mem_we_n` in place of `mem_oe_n`, with the same phase lengths, and ignores page mode. `mem_dout_en` is high from the first strobe cycle until the chip-select rises. `mem_dout` carries the write data, narrowed to `{8'h00, wdata[7:0]}` on an 8-bit bank. The active-low byte lanes `mem_be_n` are low while the chip-select is low: `~req_be` on a 16-bit bank, `{1, ~req_be[0]}` on an 8-bit bank, and for reads 2'b00 or 2'b10.
- R10: Only one access is in flight. `req_ready` stays low from acceptance until the sequence has returned to idle, and a request presented meanwhile has no effect on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_timing | input | NBANK x 25 | Per-bank packed phase counts (layout in R3) |
| cfg_wide | input | NBANK | Per-bank width: 0 = 8-bit, 1 = 16-bit |
| cfg_page | input | NBANK | Per-bank four-beat page read enable |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank |
| req_offset | input | OFS_W | Byte offset inside the bank |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Write byte enables, active high |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data of one beat |
| mem_addr | output | OFS_W | External address |
| mem_cs_n | output | NBANK | Active-low chip-selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_be_n | output | 2 | Active-low byte lane enables |
| mem_dout | output | 16 | Write data toward the bus |
| mem_dout_en | output | 1 | Drive enable for `mem_dout` |
| mem_din | input | 16 | Read data from the bus |

## Verification
The phase sequence is exercised with timing vectors that run from all-zero, where every optional phase collapses and an access takes one cycle, to all-maximum, with uneven mixes in between. These mixes show whether each phase counter is tied to the right field and whether zero-length phases are skipped rather than stretched to one cycle. Reads and writes are run on every bank and at both widths, with page mode both on and off. A write with page mode set separates page handling that wrongly reaches writes. Every access is checked cycle by cycle against a timeline built from the phase lengths while a competing request stays asserted, which exposes both wrong bank decoding and requests accepted while busy.

// File: rtl/smem_pkg.sv
// Shared types and helpers for the static memory timing controller.
// Assumes a 16-bit external data bus split into two byte lanes.
package smem_pkg;
    localparam int DATA_W     = 16;
    localparam int LANE_W     = 8;
    localparam int TIM_W      = 25;
    localparam int PAGE_BEATS = 4;
    localparam int BEAT_W     = $clog2(PAGE_BEATS);
    localparam int CNT_W      = 5;

    // Per-bank phase counts, most significant field first.
    typedef struct packed {
        logic [3:0] a_setup;
        logic [3:0] cs_setup;
        logic [4:0] access;
        logic [3:0] cs_hold;
        logic [3:0] a_hold;
        logic [3:0] page_acc;
    } tim_t;

    typedef enum logic [2:0] {
        PH_IDLE, PH_ASU, PH_CSU, PH_ACC, PH_CHD, PH_AHD
    } phase_e;

    // Counter load value (length minus one) for a phase.
    function automatic logic [CNT_W-1:0] len_m1(phase_e ph, tim_t t);
        case (ph)
            PH_ASU:  return {1'b0, t.a_setup} - 5'd1;
            PH_CSU:  return {1'b0, t.cs_setup} - 5'd1;
            PH_ACC:  return t.access;
            PH_CHD:  return {1'b0, t.cs_hold} - 5'd1;
            PH_AHD:  return {1'b0, t.a_hold} - 5'd1;
            default: return '0;
        endcase
    endfunction

    // First non-empty phase after acceptance.
    function automatic phase_e first_phase(tim_t t);
        if (t.a_setup != 4'd0)  return PH_ASU;
        if (t.cs_setup != 4'd0) return PH_CSU;
        return PH_ACC;
    endfunction

    // First non-empty phase after the strobe ends.
    function automatic phase_e after_access(tim_t t);
        if (t.cs_hold != 4'd0) return PH_CHD;
        if (t.a_hold != 4'd0)  return PH_AHD;
        return PH_IDLE;
    endfunction
endpackage

// File: rtl/smem_cfg_sel.sv
// Picks one bank's settings out of the per-bank configuration vectors.
// Assumes sel < NBANK; an out-of-range index yields all-zero settings.
module smem_cfg_sel #(
    parameter int NBANK  = 4,
    parameter int BANK_W = 2
) (
    input  logic [NBANK-1:0][smem_pkg::TIM_W-1:0] cfg_timing,
    input  logic [NBANK-1:0]                      cfg_wide,
    input  logic [NBANK-1:0]                      cfg_page,
    input  logic [BANK_W-1:0]                     sel,
    output smem_pkg::tim_t                        sel_tim,
    output logic                                  sel_wide,
    output logic                                  sel_page
);
    // Compare-and-select mux over all banks.
    always_comb begin
        sel_tim  = '0;
        sel_wide = 1'b0;
        sel_page = 1'b0;
        for (int b = 0; b < NBANK; b++) begin
            if (sel == BANK_W'(b)) begin
                sel_tim  = smem_pkg::tim_t'(cfg_timing[b]);
                sel_wide = cfg_wide[b];
                sel_page = cfg_page[b];
            end
        end
    end
endmodule

// File: rtl/smem_cs_dec.sv
// Turns an enable and a bank index into active-low chip-selects.
// Assumes at most one bank is addressed at a time.
module smem_cs_dec #(
    parameter int NBANK  = 4,
    parameter int BANK_W = 2
) (
    input  logic              en,
    input  logic [BANK_W-1:0] bank,
    output logic [NBANK-1:0]  cs_n
);
    for (genvar b = 0; b < NBANK; b++) begin : g_cs
        // One comparator per bank line.
        assign cs_n[b] = !(en && (bank == BANK_W'(b)));
    end
endmodule

// File: rtl/smem_timing_ctrl.sv
// Sequencer for asynchronous static-memory accesses over NBANK banks.
// One request at a time; settings are captured on acceptance. Phases:
// address setup, chip-select setup, strobe (access, plus page beats on
// page-mode reads), chip-select hold, address hold. Empty phases are skipped.
module smem_timing_ctrl #(
    parameter int NBANK  = 4,
    parameter int OFS_W  = 24,
    localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NBANK-1:0][smem_pkg::TIM_W-1:0] cfg_timing,
    input  logic [NBANK-1:0]                      cfg_wide,
    input  logic [NBANK-1:0]                      cfg_page,
    input  logic                                  req_valid,
    output logic                                  req_ready,
    input  logic                                  req_write,
    input  logic [BANK_W-1:0]                     req_bank,
    input  logic [OFS_W-1:0]                      req_offset,
    input  logic [smem_pkg::DATA_W-1:0]           req_wdata,
    input  logic [1:0]                            req_be,
    output logic                                  rsp_valid,
    output logic [smem_pkg::DATA_W-1:0]           rsp_rdata,
    output logic [OFS_W-1:0]                      mem_addr,
    output logic [NBANK-1:0]                      mem_cs_n,
    output logic                                  mem_oe_n,
    output logic                                  mem_we_n,
    output logic [1:0]                            mem_be_n,
    output logic [smem_pkg::DATA_W-1:0]           mem_dout,
    output logic                                  mem_dout_en,
    input  logic [smem_pkg::DATA_W-1:0]           mem_din
);
    import smem_pkg::*;

    phase_e              state, nxt_ph;
    logic [CNT_W-1:0]    cnt;
    logic [BEAT_W-1:0]   beat;
    tim_t                tim, sel_tim;
    logic                sel_wide, sel_page;
    logic                cur_wr, cur_wide, cur_page;
    logic [BANK_W-1:0]   cur_bank;
    logic [OFS_W-1:0]    cur_ofs;
    logic [DATA_W-1:0]   cur_wdata;
    logic [1:0]          cur_be;
    logic                cs_en, strobe, more_beats;

    smem_cfg_sel #(.NBANK(NBANK), .BANK_W(BANK_W)) u_sel (
        .cfg_timing(cfg_timing), .cfg_wide(cfg_wide), .cfg_page(cfg_page),
        .sel(req_bank), .sel_tim(sel_tim), .sel_wide(sel_wide),
        .sel_page(sel_page)
    );

    smem_cs_dec #(.NBANK(NBANK), .BANK_W(BANK_W)) u_cs (
        .en(cs_en), .bank(cur_bank), .cs_n(mem_cs_n)
    );

    // Phase that follows the current one once its count runs out.
    always_comb begin
        case (state)
            PH_IDLE: nxt_ph = first_phase(sel_tim);
            PH_ASU:  nxt_ph = (tim.cs_setup != 4'd0) ? PH_CSU : PH_ACC;
            PH_CSU:  nxt_ph = PH_ACC;
            PH_ACC:  nxt_ph = after_access(tim);
            PH_CHD:  nxt_ph = (tim.a_hold != 4'd0) ? PH_AHD : PH_IDLE;
            default: nxt_ph = PH_IDLE;
        endcase
    end

    assign more_beats = cur_page && !cur_wr && (beat != BEAT_W'(PAGE_BEATS - 1));

    // Phase sequencer, request capture and read sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= PH_IDLE;
            cnt       <= '0;
            beat      <= '0;
            tim       <= '0;
            cur_wr    <= 1'b0;
            cur_wide  <= 1'b0;
            cur_page  <= 1'b0;
            cur_bank  <= '0;
            cur_ofs   <= '0;
            cur_wdata <= '0;
            cur_be    <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                PH_IDLE: begin
                    if (req_valid) begin
                        tim       <= sel_tim;
                        cur_wr    <= req_write;
                        cur_wide  <= sel_wide;
                        cur_page  <= sel_page;
                        cur_bank  <= req_bank;
                        cur_ofs   <= req_offset;
                        cur_wdata <= req_wdata;
                        cur_be    <= req_be;
                        beat      <= '0;
                        state     <= nxt_ph;
                        cnt       <= len_m1(nxt_ph, sel_tim);
                    end
                end
                PH_ACC: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        if (!cur_wr) begin
                            rsp_valid <= 1'b1;
                            rsp_rdata <= cur_wide ? mem_din
                                                  : {{LANE_W{1'b0}}, mem_din[LANE_W-1:0]};
                        end
                        if (more_beats) begin
                            beat <= beat + 1'b1;
                            cnt  <= {1'b0, tim.page_acc};
                        end else begin
                            state <= nxt_ph;
                            cnt   <= len_m1(nxt_ph, tim);
                        end
                    end
                end
                default: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        state <= nxt_ph;
                        cnt   <= len_m1(nxt_ph, tim);
                    end
                end
            endcase
        end
    end

    // Bus pin decode from the registered phase.
    always_comb begin
        cs_en       = (state == PH_CSU) || (state == PH_ACC) || (state == PH_CHD);
        strobe      = (state == PH_ACC);
        req_ready   = (state == PH_IDLE);
        mem_oe_n    = !(strobe && !cur_wr);
        mem_we_n    = !(strobe && cur_wr);
        mem_dout_en = cur_wr && (strobe || (state == PH_CHD));
        mem_addr    = cur_ofs + (cur_wide ? OFS_W'({beat, 1'b0}) : OFS_W'(beat));
        mem_dout    = cur_wide ? cur_wdata : {{LANE_W{1'b0}}, cur_wdata[LANE_W-1:0]};
        if (!cs_en)      mem_be_n = 2'b11;
        else if (cur_wr) mem_be_n = cur_wide ? ~cur_be : {1'b1, ~cur_be[0]};
        else             mem_be_n = cur_wide ? 2'b00 : 2'b10;
    end
endmodule

// File: rtl/smem_timing_ctrl_chk.sv
// Protocol checker for the static memory timing controller, bound to the top.
// Observes only top-level ports.
module smem_timing_ctrl_chk #(
    parameter int NBANK = 4,
    parameter int OFS_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic [NBANK-1:0] mem_cs_n,
    input logic             mem_oe_n,
    input logic             mem_we_n,
    input logic [OFS_W-1:0] mem_addr,
    input logic             mem_dout_en,
    input logic             rsp_valid
);
    a_r1_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));

    a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    a_r4_strobe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> !(&mem_cs_n));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (&mem_cs_n && mem_oe_n && mem_we_n && !mem_dout_en));

    a_r5_rsp_after_oe: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!mem_oe_n));

    a_r9_dout_no_oe: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dout_en |-> mem_oe_n);

    a_r9_addr_steady_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));
endmodule

bind smem_timing_ctrl smem_timing_ctrl_chk #(.NBANK(NBANK), .OFS_W(OFS_W)) u_chk (.*);

// File: tb/smem_timing_ctrl_tb.sv
module smem_timing_ctrl_tb;
    localparam int NBANK = 4;
    localparam int OFS_W = 24;

    typedef struct packed {
        logic [1:0]  bank;
        logic        wr;
        logic        wide;
        logic        page;
        logic [3:0]  tacs;
        logic [3:0]  tcos;
        logic [4:0]  tacc;
        logic [3:0]  tcoh;
        logic [3:0]  tcah;
        logic [3:0]  tacp;
        logic [23:0] ofs;
        logic [15:0] wdata;
        logic [1:0]  be;
        logic [7:0]  exp_len;
    } vec_t;

    // Stimulus with hand-computed total access length (cycles until ready).
    localparam vec_t TBL [7] = '{
        '{2'd0, 1'b0, 1'b0, 1'b0, 4'd1,  4'd2,  5'd3,  4'd1,  4'd1,  4'd0,  24'h000100, 16'h0000, 2'b00, 8'd9},
        '{2'd1, 1'b1, 1'b1, 1'b0, 4'd0,  4'd0,  5'd0,  4'd0,  4'd0,  4'd0,  24'h000222, 16'hBEEF, 2'b11, 8'd1},
        '{2'd2, 1'b0, 1'b1, 1'b1, 4'd2,  4'd1,  5'd4,  4'd1,  4'd2,  4'd2,  24'h001040, 16'h0000, 2'b00, 8'd20},
        '{2'd3, 1'b1, 1'b0, 1'b0, 4'd15, 4'd15, 5'd31, 4'd15, 4'd15, 4'd15, 24'h0000F3, 16'h12C7, 2'b01, 8'd92},
        '{2'd3, 1'b0, 1'b0, 1'b1, 4'd0,  4'd0,  5'd0,  4'd0,  4'd0,  4'd0,  24'h0000FE, 16'h0000, 2'b00, 8'd4},
        '{2'd0, 1'b1, 1'b1, 1'b1, 4'd3,  4'd0,  5'd2,  4'd2,  4'd0,  4'd5,  24'h000404, 16'hA55A, 2'b10, 8'd8},
        '{2'd1, 1'b0, 1'b1, 1'b0, 4'd0,  4'd4,  5'd1,  4'd0,  4'd3,  4'd7,  24'h000777, 16'h0000, 2'b00, 8'd9}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NBANK-1:0][24:0] cfg_timing;
    logic [NBANK-1:0] cfg_wide, cfg_page;
    logic req_valid, req_ready, req_write;
    logic [1:0] req_bank;
    logic [OFS_W-1:0] req_offset;
    logic [15:0] req_wdata;
    logic [1:0] req_be;
    logic rsp_valid;
    logic [15:0] rsp_rdata;
    logic [OFS_W-1:0] mem_addr;
    logic [NBANK-1:0] mem_cs_n;
    logic mem_oe_n, mem_we_n, mem_dout_en;
    logic [1:0] mem_be_n;
    logic [15:0] mem_dout, mem_din;

    int n_checks = 0;
    int n_fail = 0;
    bit bad [6];

    always #4 clk = ~clk;

    // Device model: data depends on the address, valid only while output-enable is low.
    assign mem_din = mem_oe_n ? 16'h0000 : {~mem_addr[7:0], mem_addr[7:0] + 8'h31};

    smem_timing_ctrl #(.NBANK(NBANK), .OFS_W(OFS_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_timing(cfg_timing), .cfg_wide(cfg_wide),
        .cfg_page(cfg_page), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bank(req_bank), .req_offset(req_offset),
        .req_wdata(req_wdata), .req_be(req_be), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_be_n(mem_be_n),
        .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // Per-cycle compare; reports the first mismatch of a category in a transaction.
    task automatic cyc_cmp(input int cat, input string tag, input int t,
                           input logic [31:0] got, input logic [31:0] exp);
        if (got !== exp && !bad[cat]) begin
            bad[cat] = 1'b1;
            $display("FAIL %s at t=%0d: actual %h expected %h", tag, t, got, exp);
        end
    endtask

    function automatic logic [15:0] exp_data(input logic [23:0] a, input logic wide);
        return wide ? {~a[7:0], a[7:0] + 8'h31} : {8'h00, a[7:0] + 8'h31};
    endfunction

    task automatic run_txn(input vec_t v);
        int a_t, b_t, c_t, d_t, e_t, acc1, beat_len, step;
        bit page_rd;
        for (int b = 0; b < NBANK; b++) cfg_timing[b] = {4'd1, 4'd1, 5'd1, 4'd1, 4'd1, 4'd1};
        cfg_wide = '0;
        cfg_page = '0;
        cfg_timing[v.bank] = {v.tacs, v.tcos, v.tacc, v.tcoh, v.tcah, v.tacp};
        cfg_wide[v.bank] = v.wide;
        cfg_page[v.bank] = v.page;
        req_bank = v.bank; req_write = v.wr; req_offset = v.ofs;
        req_wdata = v.wdata; req_be = v.be; req_valid = 1'b1;
        for (int c = 0; c < 6; c++) bad[c] = 1'b0;
        page_rd  = v.page && !v.wr;
        acc1     = int'(v.tacc) + 1;
        beat_len = int'(v.tacp) + 1;
        step     = v.wide ? 2 : 1;
        a_t = int'(v.tacs);
        b_t = a_t + int'(v.tcos);
        c_t = b_t + acc1 + (page_rd ? 3 * beat_len : 0);
        d_t = c_t + int'(v.tcoh);
        e_t = d_t + int'(v.tcah);
        check("R6 table length vs phase sum", 32'(e_t), 32'(v.exp_len));
        check("R1 ready before request", 32'(req_ready), 32'd1);
        @(posedge clk);
        #1;
        // R10: a competing request stays asserted while busy
        req_bank = v.bank ^ 2'd1;
        req_write = !v.wr;
        req_offset = 24'hFFFFFF;
        for (int t = 0; t <= e_t; t++) begin
            logic [3:0] ecs;
            logic [1:0] ebe;
            int beat, rsp_k;
            @(negedge clk);
            if (t == e_t - 1) req_valid = 1'b0;
            if (t == e_t && e_t == 0) req_valid = 1'b0;
            ecs = (t >= a_t && t < d_t) ? ~(4'b0001 << v.bank) : 4'hF;
            if (ecs == 4'hF)  ebe = 2'b11;
            else if (v.wr)    ebe = v.wide ? ~v.be : {1'b1, ~v.be[0]};
            else              ebe = v.wide ? 2'b00 : 2'b10;
            cyc_cmp(0, "R1/R3/R6 chip-select", t, 32'(mem_cs_n), 32'(ecs));
            cyc_cmp(1, "R4/R5 output-enable", t, 32'(mem_oe_n),
                    32'(!(t >= b_t && t < c_t && !v.wr)));
            cyc_cmp(1, "R9 write-enable", t, 32'(mem_we_n),
                    32'(!(t >= b_t && t < c_t && v.wr)));
            cyc_cmp(4, "R9 byte lanes", t, 32'(mem_be_n), 32'(ebe));
            cyc_cmp(4, "R9 data drive", t, 32'(mem_dout_en),
                    32'(v.wr && t >= b_t && t < d_t));
            if (mem_dout_en)
                cyc_cmp(4, "R8 write data", t, 32'(mem_dout),
                        32'(v.wide ? v.wdata : {8'h00, v.wdata[7:0]}));
            cyc_cmp(5, "R6/R10 ready", t, 32'(req_ready), 32'(t == e_t));
            if (t < e_t) begin
                beat = 0;
                if (page_rd && t >= b_t + acc1) beat = 1 + (t - b_t - acc1) / beat_len;
                if (beat > 3) beat = 3;
                cyc_cmp(2, "R7/R8 address", t, 32'(mem_addr),
                        32'(v.ofs + 24'(beat * step)));
            end
            rsp_k = -1;
            if (!v.wr) begin
                for (int k = 0; k < (page_rd ? 4 : 1); k++)
                    if (t == b_t + acc1 + k * beat_len) rsp_k = k;
            end
            cyc_cmp(3, "R5/R7 response strobe", t, 32'(rsp_valid), 32'(rsp_k >= 0));
            if (rsp_k >= 0)
                cyc_cmp(3, "R5/R8 response data", t, 32'(rsp_rdata),
                        32'(exp_data(v.ofs + 24'(rsp_k * step), v.wide)));
        end
        for (int c = 0; c < 6; c++) begin
            n_checks++;
            if (bad[c]) n_fail++;
        end
    endtask

    initial begin : watchdog
        #(8 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired: actual hung expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        req_valid = 1'b0; req_write = 1'b0; req_bank = '0; req_offset = '0;
        req_wdata = '0; req_be = '0; cfg_wide = '0; cfg_page = '0;
        for (int b = 0; b < NBANK; b++) cfg_timing[b] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R2: state held in reset
        check("R2 ready in reset", 32'(req_ready), 32'd1);
        check("R2 chip-selects in reset", 32'(mem_cs_n), 32'hF);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 strobes after reset", 32'({mem_oe_n, mem_we_n, mem_be_n}), 32'hF);
        check("R2 response and drive idle", 32'({rsp_valid, mem_dout_en}), 32'd0);

        // Table walk over all vectors
        for (int i = 0; i < 7; i++) run_txn(TBL[i]);

        // R2: reset in the middle of a long write
        @(negedge clk);
        for (int b = 0; b < NBANK; b++) cfg_timing[b] = {4'd2, 4'd2, 5'd20, 4'd2, 4'd2, 4'd0};
        req_bank = 2'd2; req_write = 1'b1; req_valid = 1'b1; req_be = 2'b11;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (6) @(negedge clk);
        check("R9 write strobe active mid-access", 32'(mem_we_n), 32'd0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R2 reset aborts access: chip-selects", 32'(mem_cs_n), 32'hF);
        check("R2 reset aborts access: strobes and drive",
              32'({mem_oe_n, mem_we_n, mem_dout_en}), 32'b110);
        check("R2 reset aborts access: ready", 32'(req_ready), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // Back-to-back after the abort still works
        run_txn(TBL[4]);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule